// File: doc/BRIEF.md
# Buffer-Threshold Flow Control Engine

This block decides, port by port, when a switch should slow down the station sending into it. Each port reports how many shared packet buffers its output queue holds. When that count climbs to an upper threshold, a full-duplex port gets a PAUSE request carrying the maximal pause time 0xFFF. When the count later sinks to a lower threshold, the same port gets a PAUSE request with pause time zero so the sender resumes. A half-duplex port instead enters a backpressure state, and in that state it raises a jam request whenever carrier from an incoming frame is seen. When backpressure is switched off and the shared pool has no free buffer left, frames arriving on a port are flagged for dropping.

Both thresholds sit in one 16-bit configuration word that can be rewritten at run time. The two mode enables are captured while reset is asserted and are fixed until the next reset. A PAUSE request stays up, with a stable pause time, until the MAC acknowledges it. Building the PAUSE frame and driving the line are left to the MAC.

Top module: `bfc_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, every pause_req, jam_req and drop_rx bit is 0. The threshold word resets to upper = 64 (bits 7:0) and lower = 0x28 (bits 15:8).
- R2: On a full-duplex port with flow control enabled, an in-use count at or above the upper threshold (bits 7:0 of the threshold word) raises exactly one PAUSE request with pause_time 0xFFF, in the cycle after the count is sampled. While the port stays congested, no further request is issued.
- R3: A congested full-duplex port whose count falls to or below the lower threshold (bits 15:8) raises one PAUSE request with pause_time 0. A port that never sent the 0xFFF request never sends a zero-time request.
- R4: A PAUSE request and its pause_time stay constant until pause_ack is high at a clock edge. The request is low after that edge. No new threshold decision is taken for that port while its request is pending.
- R5: Writing the threshold word with cfg_we takes effect from the next clock edge. Bits 7:0 are the upper threshold and bits 15:8 are the lower threshold.
- R6: A half-duplex port with backpressure enabled becomes congested when its count reaches the upper threshold and leaves that state at the lower threshold. While congested, jam_req follows the port's carrier input in the same cycle. No PAUSE request is ever made for a half-duplex port.
- R7: With backpressure disabled, drop_rx of a port is 1 in the cycle after an edge at which free_cnt is 0 and that port's carrier is high, and 0 otherwise. With backpressure enabled, drop_rx stays 0.
- R8: The two strap inputs are sampled only while reset is low. Changing them after reset has no effect on the outputs.
- R9: A change in a port's full_duplex bit clears that port's congested state and any pending PAUSE request at the next edge.
- R10: With flow control disabled, a full-duplex port never raises a PAUSE request, whatever its count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fc_en_strap | input | 1 | Full-duplex PAUSE flow control enable, captured in reset |
| bp_en_strap | input | 1 | Half-duplex backpressure enable, captured in reset |
| cfg_we | input | 1 | Write strobe for the threshold word |
| cfg_wdata | input | 16 | New threshold word: [7:0] upper, [15:8] lower |
| inuse_cnt | input | NPORTS*CNT_W | Per-port output-queue buffer count, port p at [p*CNT_W +: CNT_W] |
| free_cnt | input | FREE_W | Free buffers left in the shared pool |
| full_duplex | input | NPORTS | 1 = port in full duplex, 0 = half duplex |
| carrier | input | NPORTS | Receive carrier sensed on the port |
| pause_ack | input | NPORTS | MAC has taken the pending PAUSE request |
| pause_req | output | NPORTS | PAUSE request pending on the port |
| pause_time | output | NPORTS*PT_W | Pause time for the request, port p at [p*PT_W +: PT_W] |
| jam_req | output | NPORTS | Force a collision on the port's input |
| drop_rx | output | NPORTS | Drop the frame arriving on the port |

## Verification
The bench builds the engine with four ports, 8-bit counts and a 10-bit free counter. With these sizes, two full-duplex and two half-duplex ports run side by side, and a count of 200 lies well past any threshold. The threshold word is rewritten to 20/10, which puts both hysteresis crossings within a few cycles. The bench also resets a second time with both straps low, so that the drop path and the disabled-mode behaviour are compared against the reference model in the same run.

// File: rtl/bfc_pkg.sv
// Shared constants and types for the buffer-threshold flow control engine.
// Assumes 8-bit thresholds packed into one 16-bit configuration word.
package bfc_pkg;

    localparam int THR_W = 8;

    // Threshold word layout: lower threshold in the high byte, upper in the low byte.
    typedef struct packed {
        logic [THR_W-1:0] lo;
        logic [THR_W-1:0] hi;
    } thr_cfg_t;

    localparam logic [THR_W-1:0] THR_HI_RST = 8'd64;
    localparam logic [THR_W-1:0] THR_LO_RST = 8'h28;
    localparam thr_cfg_t         THR_RST    = '{lo: THR_LO_RST, hi: THR_HI_RST};

    localparam logic [15:0] PAUSE_MAX_TIME = 16'h0FFF;

endpackage

// File: rtl/bfc_cfg.sv
// Configuration holder: the threshold word (run-time writable) and the two
// mode enables captured from strap inputs while reset is asserted.
// Assumes the strap inputs are stable around the reset release.
module bfc_cfg
    import bfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fc_en_strap,
    input  logic              bp_en_strap,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    output logic              fc_en,
    output logic              bp_en,
    output logic [THR_W-1:0]  thr_hi,
    output logic [THR_W-1:0]  thr_lo
);

    thr_cfg_t thr_q;
    logic     fc_en_q;
    logic     bp_en_q;

    // Capture straps during reset, hold them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fc_en_q <= fc_en_strap;
            bp_en_q <= bp_en_strap;
        end
    end

    // Threshold word: reset defaults, loaded on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= THR_RST;
        end else if (cfg_we) begin
            thr_q <= thr_cfg_t'(cfg_wdata);
        end
    end

    assign fc_en  = fc_en_q;
    assign bp_en  = bp_en_q;
    assign thr_hi = thr_q.hi;
    assign thr_lo = thr_q.lo;

    // R5
    thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ({thr_lo, thr_hi} == $past(cfg_wdata)));

    // R8
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(fc_en) && $stable(bp_en)));

endmodule

// File: rtl/bfc_port.sv
// Per-port flow control decision logic.
// Full duplex: hysteresis on the in-use count and PAUSE requests (0xFFF on
// entry, 0 on exit), each held until acknowledged.
// Half duplex: the same hysteresis drives a backpressure state that jams on
// carrier. Also flags drops when backpressure is off and the pool is empty.
// Assumes the lower threshold is set below the upper one.
module bfc_port
    import bfc_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fc_en,
    input  logic              bp_en,
    input  logic [THR_W-1:0]  thr_hi,
    input  logic [THR_W-1:0]  thr_lo,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              pool_empty,
    input  logic              dup_in,
    input  logic              crs,
    input  logic              ack,
    output logic              req,
    output logic [PT_W-1:0]   ptime,
    output logic              jam,
    output logic              drop
);

    localparam logic [PT_W-1:0] PT_MAX = PT_W'(PAUSE_MAX_TIME);

    logic dup_q;    // duplex seen at the last edge
    logic cong_q;   // port is above the hysteresis band
    logic pend_q;   // PAUSE request waiting for the MAC
    logic xon_q;    // pending request is the zero-time (resume) kind
    logic drop_q;

    logic at_hi;
    logic at_lo;

    // Threshold comparisons against the in-use count.
    always_comb begin
        at_hi = (cnt >= CNT_W'(thr_hi));
        at_lo = (cnt <= CNT_W'(thr_lo));
    end

    // Congestion state, pending request and duplex tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dup_q  <= dup_in;
            cong_q <= 1'b0;
            pend_q <= 1'b0;
            xon_q  <= 1'b0;
        end else if (dup_in != dup_q) begin
            dup_q  <= dup_in;
            cong_q <= 1'b0;
            pend_q <= 1'b0;
            xon_q  <= 1'b0;
        end else if (pend_q) begin
            if (ack) begin
                pend_q <= 1'b0;
            end
        end else if (dup_q) begin
            if (fc_en) begin
                if (!cong_q && at_hi) begin
                    cong_q <= 1'b1;
                    pend_q <= 1'b1;
                    xon_q  <= 1'b0;
                end else if (cong_q && at_lo) begin
                    cong_q <= 1'b0;
                    pend_q <= 1'b1;
                    xon_q  <= 1'b1;
                end
            end
        end else if (bp_en) begin
            if (!cong_q && at_hi) begin
                cong_q <= 1'b1;
            end else if (cong_q && at_lo) begin
                cong_q <= 1'b0;
            end
        end
    end

    // Drop flag when the pool is exhausted and backpressure is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_q <= 1'b0;
        end else begin
            drop_q <= !bp_en && pool_empty && crs;
        end
    end

    // Output decode.
    always_comb begin
        req   = pend_q;
        ptime = pend_q ? (xon_q ? '0 : PT_MAX) : '0;
        jam   = !dup_q && bp_en && cong_q && crs;
        drop  = drop_q;
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && (dup_in == dup_q)) |=> (req && $stable(ptime)));

    // R9
    dup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dup_in != dup_q) |=> (!req && !cong_q));

    // R6
    jam_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jam |-> (!req && crs && bp_en));

    // R3
    xon_after_xoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (ptime == '0)) |-> !cong_q);

    // R2
    xoff_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (ptime != '0)) |-> (cong_q && dup_q));

    // R10
    fc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> fc_en);

    // R7
    drop_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> !bp_en);

endmodule

// File: rtl/bfc_engine.sv
// Top of the buffer-threshold flow control engine: one configuration holder
// shared by a generated array of per-port deciders.
// Assumes inuse_cnt and free_cnt are synchronous to clk.
module bfc_engine
    import bfc_pkg::*;
#(
    parameter int NPORTS = 16,
    parameter int CNT_W  = 8,
    parameter int FREE_W = 12,
    parameter int PT_W   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fc_en_strap,
    input  logic                   bp_en_strap,
    input  logic                   cfg_we,
    input  logic [15:0]            cfg_wdata,
    input  logic [NPORTS*CNT_W-1:0] inuse_cnt,
    input  logic [FREE_W-1:0]      free_cnt,
    input  logic [NPORTS-1:0]      full_duplex,
    input  logic [NPORTS-1:0]      carrier,
    input  logic [NPORTS-1:0]      pause_ack,
    output logic [NPORTS-1:0]      pause_req,
    output logic [NPORTS*PT_W-1:0] pause_time,
    output logic [NPORTS-1:0]      jam_req,
    output logic [NPORTS-1:0]      drop_rx
);

    logic             fc_en;
    logic             bp_en;
    logic [THR_W-1:0] thr_hi;
    logic [THR_W-1:0] thr_lo;
    logic             pool_empty;

    // Shared pool exhaustion flag.
    assign pool_empty = (free_cnt == '0);

    bfc_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .fc_en_strap (fc_en_strap),
        .bp_en_strap (bp_en_strap),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .fc_en       (fc_en),
        .bp_en       (bp_en),
        .thr_hi      (thr_hi),
        .thr_lo      (thr_lo)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        bfc_port #(
            .CNT_W (CNT_W),
            .PT_W  (PT_W)
        ) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .fc_en      (fc_en),
            .bp_en      (bp_en),
            .thr_hi     (thr_hi),
            .thr_lo     (thr_lo),
            .cnt        (inuse_cnt[p*CNT_W +: CNT_W]),
            .pool_empty (pool_empty),
            .dup_in     (full_duplex[p]),
            .crs        (carrier[p]),
            .ack        (pause_ack[p]),
            .req        (pause_req[p]),
            .ptime      (pause_time[p*PT_W +: PT_W]),
            .jam        (jam_req[p]),
            .drop       (drop_rx[p])
        );
    end

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> ((pause_req == '0) && (jam_req == '0) && (drop_rx == '0)));

endmodule

// File: tb/bfc_engine_tb_top.sv
// Bench: behavioural reference model compared on every falling edge, plus
// directed checks at the threshold crossings.
module bfc_engine_tb_top;

    localparam int N      = 4;
    localparam int CNT_W  = 8;
    localparam int FREE_W = 10;
    localparam int PT_W   = 16;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  fc_strap = 1'b1;
    logic                  bp_strap = 1'b1;
    logic                  cfg_we = 1'b0;
    logic [15:0]           cfg_wdata = '0;
    logic [N*CNT_W-1:0]    inuse_cnt = '0;
    logic [FREE_W-1:0]     free_cnt = 10'd100;
    logic [N-1:0]          full_duplex = 4'b0011;
    logic [N-1:0]          carrier = '0;
    logic [N-1:0]          pause_ack = '0;
    logic [N-1:0]          pause_req;
    logic [N*PT_W-1:0]     pause_time;
    logic [N-1:0]          jam_req;
    logic [N-1:0]          drop_rx;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bfc_engine #(.NPORTS(N), .CNT_W(CNT_W), .FREE_W(FREE_W), .PT_W(PT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .fc_en_strap(fc_strap), .bp_en_strap(bp_strap),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .inuse_cnt(inuse_cnt),
        .free_cnt(free_cnt), .full_duplex(full_duplex), .carrier(carrier),
        .pause_ack(pause_ack), .pause_req(pause_req), .pause_time(pause_time),
        .jam_req(jam_req), .drop_rx(drop_rx)
    );

    // Reference model state
    int m_hi, m_lo;
    bit m_fc, m_bp;
    bit m_dup [N];
    bit m_cong[N];
    bit m_pend[N];
    bit m_xon [N];
    bit m_drop[N];

    // Model update at every rising edge from the inputs held since the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = 64; m_lo = 40;
            m_fc = fc_strap; m_bp = bp_strap;
            for (int p = 0; p < N; p++) begin
                m_dup[p] = full_duplex[p]; m_cong[p] = 0; m_pend[p] = 0;
                m_xon[p] = 0; m_drop[p] = 0;
            end
        end else begin
            for (int p = 0; p < N; p++) begin
                int c;
                c = int'(inuse_cnt[p*CNT_W +: CNT_W]);
                m_drop[p] = !m_bp && (free_cnt == 0) && carrier[p];
                if (full_duplex[p] != m_dup[p]) begin
                    m_dup[p] = full_duplex[p]; m_cong[p] = 0; m_pend[p] = 0; m_xon[p] = 0;
                end else if (m_pend[p]) begin
                    if (pause_ack[p]) m_pend[p] = 0;
                end else if (m_dup[p]) begin
                    if (m_fc && !m_cong[p] && c >= m_hi) begin
                        m_cong[p] = 1; m_pend[p] = 1; m_xon[p] = 0;
                    end else if (m_fc && m_cong[p] && c <= m_lo) begin
                        m_cong[p] = 0; m_pend[p] = 1; m_xon[p] = 1;
                    end
                end else if (m_bp) begin
                    if (!m_cong[p] && c >= m_hi) m_cong[p] = 1;
                    else if (m_cong[p] && c <= m_lo) m_cong[p] = 0;
                end
            end
            if (cfg_we) begin
                m_hi = int'(cfg_wdata[7:0]);
                m_lo = int'(cfg_wdata[15:8]);
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < N; p++) begin
                int et;
                bit ej;
                et = m_pend[p] ? (m_xon[p] ? 0 : 'hFFF) : 0;
                ej = !m_dup[p] && m_bp && m_cong[p] && carrier[p];
                checks++;
                if (pause_req[p] !== m_pend[p] || int'(pause_time[p*PT_W +: PT_W]) != et) begin
                    errors++;
                    $display("FAIL R4 model port %0d: req/time %b/%h expected %b/%h",
                             p, pause_req[p], pause_time[p*PT_W +: PT_W], m_pend[p], et);
                end
                if (jam_req[p] !== ej) begin
                    errors++;
                    $display("FAIL R6 model port %0d: jam %b expected %b", p, jam_req[p], ej);
                end
                if (drop_rx[p] !== m_drop[p]) begin
                    errors++;
                    $display("FAIL R7 model port %0d: drop %b expected %b", p, drop_rx[p], m_drop[p]);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_cnt(input int p, input int v);
        inuse_cnt[p*CNT_W +: CNT_W] = CNT_W'(v);
    endtask

    function automatic int ptime_of(input int p);
        return int'(pause_time[p*PT_W +: PT_W]);
    endfunction

    task automatic do_reset(input bit fc, input bit bp);
        rst_n = 1'b0; fc_strap = fc; bp_strap = bp;
        tick(3);
        rst_n = 1'b1;
    endtask

    bit done = 0;

    initial begin
        tick(1);
        do_reset(1'b1, 1'b1);
        tick(1);
        // R1: quiet outputs after reset
        chk(pause_req == 0 && jam_req == 0 && drop_rx == 0, "R1 reset outputs",
            int'({pause_req, jam_req, drop_rx}), 0);

        // R1, R2: default upper threshold is 64
        set_cnt(0, 63); tick(3);
        chk(pause_req[0] == 0, "R1 default upper 64 not reached at 63", pause_req[0], 0);
        set_cnt(0, 64); tick(1);
        chk(pause_req[0] == 1 && ptime_of(0) == 'hFFF, "R2 XOFF at upper", ptime_of(0), 'hFFF);
        // R4: hold without ack
        tick(3);
        chk(pause_req[0] == 1 && ptime_of(0) == 'hFFF, "R4 request held", pause_req[0], 1);
        pause_ack[0] = 1; tick(1); pause_ack[0] = 0;
        chk(pause_req[0] == 0, "R4 request cleared by ack", pause_req[0], 0);
        set_cnt(0, 90); tick(3);
        chk(pause_req[0] == 0, "R2 no repeat while congested", pause_req[0], 0);

        // R3: resume at lower threshold 0x28
        set_cnt(0, 41); tick(2);
        chk(pause_req[0] == 0, "R3 above lower", pause_req[0], 0);
        set_cnt(0, 40); tick(1);
        chk(pause_req[0] == 1 && ptime_of(0) == 0, "R3 XON time zero", ptime_of(0), 0);
        pause_ack[0] = 1; tick(1); pause_ack[0] = 0;
        set_cnt(0, 5); tick(3);
        chk(pause_req[0] == 0, "R3 no XON without prior XOFF", pause_req[0], 0);

        // R5: new thresholds upper 20 (bits 7:0), lower 10 (bits 15:8)
        cfg_we = 1; cfg_wdata = {8'd10, 8'd20}; tick(1); cfg_we = 0;
        set_cnt(1, 20); tick(1);
        chk(pause_req[1] == 1 && ptime_of(1) == 'hFFF, "R5 new upper threshold", pause_req[1], 1);
        pause_ack[1] = 1; tick(1); pause_ack[1] = 0;
        set_cnt(1, 10); tick(1);
        chk(pause_req[1] == 1 && ptime_of(1) == 0, "R5 new lower threshold", ptime_of(1), 0);
        pause_ack[1] = 1; tick(1); pause_ack[1] = 0;

        // R6: half-duplex backpressure on port 2
        set_cnt(2, 20); tick(2);
        chk(jam_req[2] == 0, "R6 no jam without carrier", jam_req[2], 0);
        carrier[2] = 1; #1;
        chk(jam_req[2] == 1 && pause_req[2] == 0, "R6 jam with carrier", jam_req[2], 1);
        set_cnt(2, 15); tick(2);
        chk(jam_req[2] == 1, "R6 hysteresis keeps jam", jam_req[2], 1);
        set_cnt(2, 10); tick(1);
        chk(jam_req[2] == 0, "R6 jam released at lower", jam_req[2], 0);
        carrier[2] = 0;

        // R9: duplex change drops pending request
        set_cnt(3, 0); full_duplex[3] = 1; tick(2);
        set_cnt(3, 25); tick(1);
        chk(pause_req[3] == 1, "R9 request pending", pause_req[3], 1);
        full_duplex[3] = 0; tick(1);
        chk(pause_req[3] == 0, "R9 cleared on duplex change", pause_req[3], 0);
        tick(2);

        // R8: straps changed after reset have no effect; R7 with bp on
        bp_strap = 0; fc_strap = 0;
        free_cnt = 0; carrier[1] = 1; tick(2);
        chk(drop_rx[1] == 0, "R8 strap change ignored, no drop", drop_rx[1], 0);
        carrier[1] = 0; free_cnt = 10'd50; tick(1);

        // R7, R10: reset with both enables off
        set_cnt(0, 0); set_cnt(1, 0); set_cnt(2, 0); set_cnt(3, 0);
        do_reset(1'b0, 1'b0);
        tick(1);
        free_cnt = 0; carrier = 4'b0101; tick(1);
        chk(drop_rx == 4'b0101, "R7 drop when pool empty", drop_rx, 4'b0101);
        free_cnt = 10'd1; tick(1);
        chk(drop_rx == 0, "R7 no drop with free buffer", drop_rx, 0);
        set_cnt(0, 200); set_cnt(2, 200); tick(3);
        chk(pause_req[0] == 0, "R10 no pause with flow control off", pause_req[0], 0);
        chk(jam_req[2] == 0, "R6 no jam with backpressure off", jam_req[2], 0);
        carrier = 0; tick(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule